// File: doc/BRIEF.md
# ADC Result Register Read Lock

This block sits between an analog-to-digital converter and the register bus. It keeps the latest conversion result in a pair of byte-wide registers, a high byte and a low byte, and decides for every finished conversion whether the new value may replace the one already held. A value that has been moved into the registers marks the conversion as complete. The block raises a completion flag and, when enabled, an interrupt.

Software reads a wide result in two steps, first the high byte and then the low byte. In the 10-bit and 12-bit resolutions, a read of the high byte locks the pair until the low byte is read. This keeps the two halves from coming from different conversions. A conversion that finishes while the pair is locked is discarded, and the block asks the converter for a fresh one. The only exception is a single conversion whose compare check failed, which simply ends. While the lock is held and the queued-channel option is on, the block also tells the channel sequencer to stay on its current entry.

Top module: `adc_result_lock`

## Requirements
- R1: When a result strobe arrives, the pair is not locked and the compare check passes, the result is loaded into the high and low registers and the completion flag is set in the next cycle.
- R2: The interrupt output is high exactly while the completion flag is set and the interrupt enable input is high.
- R3: With resolution code 2'b01 (10-bit) or 2'b10/2'b11 (12-bit), a high-byte read arms the lock. A later low-byte read releases it, and a low-byte read in the same cycle as a result strobe releases it in time for that result to load.
- R4: A result strobe that arrives while the lock is held leaves both registers unchanged and does not set the completion flag.
- R5: A discarded (locked-out) result produces a one-cycle conversion-restart pulse in the following cycle, whether the continuous-mode input is high or low.
- R6: A locked-out result in single mode (continuous input low), with the compare check enabled and false, produces no restart pulse.
- R7: The sequencer-hold output is high while the lock is held and the queue option input is high, and it is low otherwise.
- R8: With resolution code 2'b00 (8-bit), a high-byte read never arms the lock, and a loaded result places its bits [7:0] in the low register and zero in the high register.
- R9: A low-byte read clears the completion flag, but a load in the same cycle leaves the flag set. Reset clears the flag, the lock, the restart pulse and both registers.
- R10: Results are right-justified: in 12-bit mode the high register holds result bits [11:8] with bits [7:4] zero, and in 10-bit mode it holds result bits [9:8] with bits [7:2] zero.
- R11: In 10-bit or 12-bit mode, a high-byte read in the same cycle as a result strobe locks that result out.
- R12: A result strobe that is not locked out but has the compare check enabled and false loads nothing, leaves the flag unchanged and requests no restart.

Top module port list below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Conversion finished strobe, one cycle |
| res_data_i | input | 12 | Right-justified conversion result |
| res_mode_i | input | 2 | Resolution: 00 8-bit, 01 10-bit, 10/11 12-bit |
| cmp_en_i | input | 1 | Compare check enabled |
| cmp_true_i | input | 1 | Compare condition met for this result |
| cont_i | input | 1 | Continuous conversion mode |
| irq_en_i | input | 1 | Interrupt enable |
| queue_en_i | input | 1 | Queued-channel option enabled |
| rd_hi_i | input | 1 | Bus read of the high byte |
| rd_lo_i | input | 1 | Bus read of the low byte |
| res_hi_o | output | 8 | High result byte |
| res_lo_o | output | 8 | Low result byte |
| done_o | output | 1 | Conversion completion flag |
| irq_o | output | 1 | Interrupt request |
| restart_o | output | 1 | Request to start another conversion |
| queue_hold_o | output | 1 | Hold the channel and result queues |

## Verification
Two pairs of events can fall in the same clock cycle. The first is a result strobe together with a high-byte read, where the result must be locked out at once even though the lock register has not yet armed. The second is a result strobe together with a low-byte read, where the lock must release in time for the load and the flag's set must win over the read's clear. The scoreboard driver issues the strobe in the very cycle of the read pulse and queues the expected register, flag and restart values. The monitor then compares them on the next falling edge, and a port-level check of the hold output confirms the lock state left behind.

// File: rtl/adc_lock_pkg.sv
package adc_lock_pkg;

   localparam logic [1:0] MODE_8  = 2'b00;
   localparam logic [1:0] MODE_10 = 2'b01;

   // Wide modes read the result in two bus accesses and need the lock.
   function automatic logic is_wide(input logic [1:0] mode);
      return mode != MODE_8;
   endfunction

   // Number of meaningful high-byte bits for the given mode.
   function automatic int unsigned hi_bits(input logic [1:0] mode,
                                           input int unsigned res_w,
                                           input int unsigned mid_w,
                                           input int unsigned byte_w);
      if (mode == MODE_8)  return 0;
      if (mode == MODE_10) return mid_w - byte_w;
      return res_w - byte_w;
   endfunction

endpackage

// File: rtl/adc_lock_tracker.sv
module adc_lock_tracker (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rd_hi_i,
   input  logic rd_lo_i,
   input  logic wide_i,
   output logic lock_o
);

   logic lock_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                lock_q <= 1'b0;
      else if (rd_lo_i)           lock_q <= 1'b0;
      else if (rd_hi_i && wide_i) lock_q <= 1'b1;
   end

   assign lock_o = lock_q;

endmodule

// File: rtl/adc_xfer_ctrl.sv
module adc_xfer_ctrl (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic valid_i,
   input  logic blocked_i,
   input  logic cmp_en_i,
   input  logic cmp_true_i,
   input  logic cont_i,
   input  logic rd_lo_i,
   output logic load_o,
   output logic done_o,
   output logic restart_o
);

   logic cmp_fail;
   logic single_fail;
   logic done_q;
   logic restart_q;

   assign cmp_fail    = cmp_en_i && !cmp_true_i;
   assign single_fail = cmp_fail && !cont_i;
   assign load_o      = valid_i && !blocked_i && !cmp_fail;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         done_q    <= 1'b0;
         restart_q <= 1'b0;
      end else begin
         if (load_o)       done_q <= 1'b1;
         else if (rd_lo_i) done_q <= 1'b0;
         restart_q <= valid_i && blocked_i && !single_fail;
      end
   end

   assign done_o    = done_q;
   assign restart_o = restart_q;

endmodule

// File: rtl/adc_result_store.sv
module adc_result_store #(
   parameter int unsigned RES_W  = 12,
   parameter int unsigned MID_W  = 10,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [1:0]        mode_i,
   input  logic [RES_W-1:0]  data_i,
   output logic [BYTE_W-1:0] hi_o,
   output logic [BYTE_W-1:0] lo_o
);

   import adc_lock_pkg::*;

   logic [BYTE_W-1:0] hi_d;
   logic [BYTE_W-1:0] hi_q;
   logic [BYTE_W-1:0] lo_q;
   int unsigned       keep_n;

   assign keep_n = hi_bits(mode_i, RES_W, MID_W, BYTE_W);

   for (genvar b = 0; b < BYTE_W; b++) begin : g_hi
      if (BYTE_W + b < RES_W) begin : g_src
         assign hi_d[b] = (b < keep_n) ? data_i[BYTE_W+b] : 1'b0;
      end else begin : g_zero
         assign hi_d[b] = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (load_i) begin
         hi_q <= hi_d;
         lo_q <= data_i[BYTE_W-1:0];
      end
   end

   assign hi_o = hi_q;
   assign lo_o = lo_q;

endmodule

// File: rtl/adc_result_lock.sv
module adc_result_lock #(
   parameter int unsigned RES_W  = 12,
   parameter int unsigned MID_W  = 10,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              res_valid_i,
   input  logic [RES_W-1:0]  res_data_i,
   input  logic [1:0]        res_mode_i,
   input  logic              cmp_en_i,
   input  logic              cmp_true_i,
   input  logic              cont_i,
   input  logic              irq_en_i,
   input  logic              queue_en_i,
   input  logic              rd_hi_i,
   input  logic              rd_lo_i,
   output logic [BYTE_W-1:0] res_hi_o,
   output logic [BYTE_W-1:0] res_lo_o,
   output logic              done_o,
   output logic              irq_o,
   output logic              restart_o,
   output logic              queue_hold_o
);

   import adc_lock_pkg::*;

   if (RES_W <= BYTE_W || RES_W > 2 * BYTE_W) begin : g_bad_res
      $error("RES_W must exceed BYTE_W and fit in two bytes");
   end
   if (MID_W < BYTE_W || MID_W > RES_W) begin : g_bad_mid
      $error("MID_W must lie between BYTE_W and RES_W");
   end

   logic wide;
   logic lock_q;
   logic blocked;
   logic load;

   assign wide    = is_wide(res_mode_i);
   // A low-byte read releases the lock; a high-byte read locks at once.
   assign blocked = !rd_lo_i && (lock_q || (rd_hi_i && wide));

   adc_lock_tracker i_lock (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rd_hi_i (rd_hi_i),
      .rd_lo_i (rd_lo_i),
      .wide_i  (wide),
      .lock_o  (lock_q)
   );

   adc_xfer_ctrl i_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .valid_i    (res_valid_i),
      .blocked_i  (blocked),
      .cmp_en_i   (cmp_en_i),
      .cmp_true_i (cmp_true_i),
      .cont_i     (cont_i),
      .rd_lo_i    (rd_lo_i),
      .load_o     (load),
      .done_o     (done_o),
      .restart_o  (restart_o)
   );

   adc_result_store #(
      .RES_W  (RES_W),
      .MID_W  (MID_W),
      .BYTE_W (BYTE_W)
   ) i_store (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .mode_i (res_mode_i),
      .data_i (res_data_i),
      .hi_o   (res_hi_o),
      .lo_o   (res_lo_o)
   );

   assign irq_o        = done_o && irq_en_i;
   assign queue_hold_o = queue_en_i && lock_q;

endmodule

// File: rtl/adc_lock_chk.sv
module adc_lock_chk #(
   parameter int unsigned BYTE_W = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              res_valid_i,
   input logic [1:0]        res_mode_i,
   input logic              irq_en_i,
   input logic              rd_hi_i,
   input logic              rd_lo_i,
   input logic              lock_q,
   input logic [BYTE_W-1:0] res_hi_o,
   input logic [BYTE_W-1:0] res_lo_o,
   input logic              done_o,
   input logic              irq_o,
   input logic              restart_o,
   input logic              queue_hold_o
);

   AST_LOCKED_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_q && !rd_lo_i && res_valid_i) |=> ($stable(res_hi_o) && $stable(res_lo_o))); // R4

   AST_LOCKED_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_q && !rd_lo_i && res_valid_i && !done_o) |=> !done_o); // R4

   AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && irq_en_i) |-> irq_o); // R2

   AST_RESTART_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_o |-> $past(res_valid_i)); // R5

   AST_NARROW_NO_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_mode_i == 2'b00 && !lock_q) |=> !lock_q); // R8

   AST_HOLD_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      queue_hold_o |-> lock_q); // R7

   AST_HI_READ_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_hi_i && !rd_lo_i && res_mode_i != 2'b00) |=> lock_q); // R3

   AST_LO_READ_UNLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_lo_i |=> !lock_q); // R3

endmodule

bind adc_result_lock adc_lock_chk #(.BYTE_W(BYTE_W)) i_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .res_valid_i  (res_valid_i),
   .res_mode_i   (res_mode_i),
   .irq_en_i     (irq_en_i),
   .rd_hi_i      (rd_hi_i),
   .rd_lo_i      (rd_lo_i),
   .lock_q       (lock_q),
   .res_hi_o     (res_hi_o),
   .res_lo_o     (res_lo_o),
   .done_o       (done_o),
   .irq_o        (irq_o),
   .restart_o    (restart_o),
   .queue_hold_o (queue_hold_o)
);

// File: tb/test_adc_result_lock.sv
`timescale 1ns/1ps
module test_adc_result_lock;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_valid = 1'b0;
   logic [11:0] res_data = '0;
   logic [1:0]  res_mode = 2'b10;
   logic        cmp_en = 1'b0, cmp_true = 1'b0, cont = 1'b0;
   logic        irq_en = 1'b0, queue_en = 1'b1;
   logic        rd_hi = 1'b0, rd_lo = 1'b0;
   logic [7:0]  res_hi, res_lo;
   logic        done, irq, restart, queue_hold;

   always #4 clk = ~clk;

   adc_result_lock i_adc_result_lock (
      .clk_i (clk), .rst_ni (rst_n),
      .res_valid_i (res_valid), .res_data_i (res_data), .res_mode_i (res_mode),
      .cmp_en_i (cmp_en), .cmp_true_i (cmp_true), .cont_i (cont),
      .irq_en_i (irq_en), .queue_en_i (queue_en),
      .rd_hi_i (rd_hi), .rd_lo_i (rd_lo),
      .res_hi_o (res_hi), .res_lo_o (res_lo), .done_o (done),
      .irq_o (irq), .restart_o (restart), .queue_hold_o (queue_hold)
   );

   int          n_run = 0;
   int          n_fail = 0;
   logic [17:0] exp_q[$];
   string       req_q[$];
   logic        vld_seen = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Driver: one result strobe, optional same-cycle reads, expected outcome queued.
   task automatic send(input logic [11:0] d, input bit h, input bit l,
                       input logic [7:0] eh, input logic [7:0] el,
                       input bit ed, input bit er, input string req);
      @(negedge clk);
      exp_q.push_back({eh, el, ed, er});
      req_q.push_back(req);
      res_data  = d;
      res_valid = 1'b1;
      rd_hi     = h;
      rd_lo     = l;
      @(negedge clk);
      res_valid = 1'b0;
      rd_hi     = 1'b0;
      rd_lo     = 1'b0;
   endtask

   task automatic pulse_hi();
      @(negedge clk); rd_hi = 1'b1;
      @(negedge clk); rd_hi = 1'b0;
   endtask

   task automatic pulse_lo();
      @(negedge clk); rd_lo = 1'b1;
      @(negedge clk); rd_lo = 1'b0;
   endtask

   always @(posedge clk) vld_seen <= res_valid;

   // Monitor: compare outputs one cycle after each strobe.
   always @(negedge clk) begin
      if (vld_seen) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "SCOREBOARD", 0, 1);
         end else begin
            logic [17:0] e;
            string       r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            chk({res_hi, res_lo, done, restart} == e, r,
                int'({res_hi, res_lo, done, restart}), int'(e));
         end
      end
   end

   initial begin
      #(200000 * 8);
      chk(1'b0, "WATCHDOG", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk({res_hi, res_lo, done, irq, restart, queue_hold} == '0, "R9 reset",
          int'({res_hi, res_lo}), 0);
      rst_n = 1'b1;
      irq_en = 1'b1;

      // R1 R10: 12-bit load
      send(12'hABC, 0, 0, 8'h0A, 8'hBC, 1, 0, "R1 R10 12-bit load");
      chk(irq == 1'b1, "R2 irq with enable", irq, 1);
      irq_en = 1'b0; #1;
      chk(irq == 1'b0, "R2 irq masked", irq, 0);
      pulse_lo();
      chk(done == 1'b0, "R9 low read clears flag", done, 0);

      // R3 R7: high read locks
      pulse_hi();
      chk(queue_hold == 1'b1, "R3 R7 lock armed", queue_hold, 1);
      queue_en = 1'b0; #1;
      chk(queue_hold == 1'b0, "R7 hold needs option", queue_hold, 0);
      queue_en = 1'b1;
      send(12'h123, 0, 0, 8'h0A, 8'hBC, 0, 1, "R4 R5 blocked single");
      cont = 1'b1;
      send(12'h456, 0, 0, 8'h0A, 8'hBC, 0, 1, "R5 blocked continuous");
      cont = 1'b0; cmp_en = 1'b1; cmp_true = 1'b0;
      send(12'h789, 0, 0, 8'h0A, 8'hBC, 0, 0, "R6 single compare false");
      cmp_en = 1'b0;
      pulse_lo();
      chk(queue_hold == 1'b0, "R3 low read releases", queue_hold, 0);
      send(12'h321, 0, 0, 8'h03, 8'h21, 1, 0, "R1 load after release");

      // R10: 10-bit justification
      res_mode = 2'b01;
      send(12'hFFF, 0, 0, 8'h03, 8'hFF, 1, 0, "R10 10-bit upper zero");

      // R8: 8-bit mode never locks
      res_mode = 2'b00;
      pulse_lo();
      pulse_hi();
      chk(queue_hold == 1'b0, "R8 no lock in 8-bit", queue_hold, 0);
      send(12'h5A7, 0, 0, 8'h00, 8'hA7, 1, 0, "R8 8-bit load");

      // R11: high read in the strobe cycle
      res_mode = 2'b10;
      send(12'h654, 1, 0, 8'h00, 8'hA7, 1, 1, "R11 same-cycle high read");
      chk(queue_hold == 1'b1, "R11 lock left armed", queue_hold, 1);
      // R3 R9: low read in the strobe cycle releases and set wins
      send(12'h777, 0, 1, 8'h07, 8'h77, 1, 0, "R3 R9 same-cycle low read");
      chk(queue_hold == 1'b0, "R3 released", queue_hold, 0);

      // R12: compare false, unlocked
      pulse_lo();
      cmp_en = 1'b1; cmp_true = 1'b0;
      send(12'h111, 0, 0, 8'h07, 8'h77, 0, 0, "R12 compare false no load");
      cmp_true = 1'b1;
      send(12'h222, 0, 0, 8'h02, 8'h22, 1, 0, "R12 compare true loads");
      cmp_en = 1'b0;

      // R9: reset clears everything, lock included
      pulse_hi();
      @(negedge clk); rst_n = 1'b0; #1;
      chk({res_hi, res_lo, done, restart, queue_hold} == '0, "R9 reset mid-run",
          int'({res_hi, res_lo, done, queue_hold}), 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk(exp_q.size() == 0, "SCOREBOARD drained", exp_q.size(), 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule